// File: doc/BRIEF.md
# Row-Tracking Precharge Sequencer for a Word-Wide Static-Style Memory

The block puts a synchronous front end on a 16-bit-wide memory array. It accepts the signals of an asynchronous static RAM: an active-low chip select, write strobe and read strobe, two active-low byte-lane selects, a 17-bit word address and a 16-bit data input. All of these are sampled on the rising clock edge. The address is split into a row part, bits 16:2, and a column part, bits 1:0. The block keeps one row open at a time. Raising the chip select, or changing any row bit, closes the open row and starts a precharge phase. When a column changes while the row stays the same, the block serves it at once as a page access.

Precharge length, address access latency and the minimum spacing between random accesses are parameters counted in clock cycles. A busy output shows when a new random access cannot begin yet. Writes wait in a hold register and go into the array, one byte lane at a time, when the write strobe rises, when chip select rises, or when the address moves. The array is a behavioural store of 2**STORE_W words. It is indexed by the low STORE_W bits of the address, so higher addresses alias onto it. A low-supply input blocks every array access for as long as it is asserted.

Top module: `sram_row_seq`

## Requirements
- R1: While reset is asserted, busy is 1 and dout_en is 2'b00.
- R2: Chip select sampled high while a row is open closes the row. If the spacing rule of R5 is already met, busy stays 1 for exactly PRE_CYC clock samples, then drops to 0 while chip select remains high.
- R3: An access started from the idle-ready state (chip select sampled low while busy is 0) keeps busy at 1 for exactly AA_CYC samples. Busy then drops and the addressed word appears on dout.
- R4: A change in address bits 16:2 while a row is open closes it. Busy rises on the next sample. When the row had been open long enough, busy lasts PRE_CYC+AA_CYC samples and the new row's data follows.
- R5: Two random access starts are at least RC_CYC clocks apart. A row change right after an access opens keeps busy for max(PRE_CYC, RC_CYC-AA_CYC-1)+AA_CYC samples.
- R6: A change confined to address bits 1:0 with the row open keeps busy at 0. dout shows the newly addressed word on the next sample.
- R7: dout_en[1] (bits 15:8) and dout_en[0] (bits 7:0) are 1 only when a row is open, chip select and read strobe are low, the write strobe is high, supply is good and that lane's select is low. Otherwise they are 0.
- R8: A write commits on the write strobe's rising edge. It stores only the lanes whose select was low, and each other lane keeps its old content.
- R9: If chip select rises while the write strobe is still low, the pending write is committed before the row closes.
- R10: While low_supply is 1, busy is 1, dout_en is 2'b00 and no write reaches the array, including a pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_supply | input | 1 | Brown-out indication, blocks all array access |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read strobe |
| ub_n | input | 1 | Active-low select for data bits 15:8 |
| lb_n | input | 1 | Active-low select for data bits 7:0 |
| addr | input | 17 | Word address, bits 16:2 row, bits 1:0 column |
| din | input | 16 | Write data |
| dout | output | 16 | Read data of the addressed word |
| dout_en | output | 2 | Per-lane output drive enable (tri-state model) |
| busy | output | 1 | High while precharge or access latency runs |

## Verification
A wrong phase in the sequencer appears on busy within a single sample. Busy that stays low after a row change, or that runs one cycle too long or too short, is caught by cycle-exact counts of busy samples. A wrong column register or a lost pending write appears as a wrong dout word on the next read of that address. Because the read path is combinational from the registered column, this shows one sample after the address is presented. A lane-mask error shows as the wrong half of a word after a partial write, or as a wrong dout_en bit in the same sample.

// File: rtl/sram_row_seq_pkg.sv
package sram_row_seq_pkg;

  typedef enum logic [1:0] {
    ST_PRE  = 2'd0,
    ST_RDY  = 2'd1,
    ST_ACC  = 2'd2,
    ST_OPEN = 2'd3
  } seq_state_e;

  // True when the edge that follows completes a span of lim cycles,
  // given cnt cycles already elapsed.
  function automatic logic span_met(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  // Active-high lane mask from the active-low byte selects.
  function automatic logic [1:0] lane_mask(input logic upper_n, input logic lower_n);
    return {~upper_n, ~lower_n};
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seq_sat_counter.sv
module seq_sat_counter #(
  parameter int W        = 8,
  parameter bit RST_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= {W{RST_FULL}};
    else if (clr)          cnt <= '0;
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/seq_lane_array.sv
module seq_lane_array #(
  parameter int DW    = 16,
  parameter int LANES = 2,
  parameter int SW    = 10
) (
  input  logic             clk,
  input  logic [LANES-1:0] wr_lane,
  input  logic [SW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [SW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << SW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_lane[g]) bank[waddr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = bank[raddr];
  end
endmodule

// File: rtl/sram_row_seq.sv
module sram_row_seq
  import sram_row_seq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 16,
  parameter int COL_W   = 2,
  parameter int STORE_W = 10,
  parameter int PRE_CYC = 3,
  parameter int AA_CYC  = 4,
  parameter int RC_CYC  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_supply,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [1:0]        dout_en,
  output logic              busy
);
  localparam int LIM_MAX = max3(PRE_CYC, AA_CYC, RC_CYC);
  localparam int CNT_W   = $clog2(LIM_MAX + 1) + 1;
  localparam int LANES   = 2;

  seq_state_e state, nxt;
  logic [ADDR_W-1:0] cur_q;
  logic [CNT_W-1:0]  pre_cnt, acc_cnt;
  logic              row_chg, pre_done, aa_done;
  logic              pre_start, acc_start, open_start, st_open;

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [LANES-1:0]  pend_be_q;
  logic              pend_load, wr_commit, rd_ok;
  logic [DATA_W-1:0] rdata;

  // Event wires, also observed by the bound checker.
  assign row_chg  = addr[ADDR_W-1:COL_W] != cur_q[ADDR_W-1:COL_W];
  assign pre_done = span_met(32'(pre_cnt), PRE_CYC) && span_met(32'(acc_cnt), RC_CYC);
  assign aa_done  = span_met(32'(acc_cnt), AA_CYC);
  assign st_open  = state == ST_OPEN;

  always_comb begin
    nxt = state;
    if (low_supply) nxt = ST_PRE;
    else begin
      case (state)
        ST_PRE:  if (pre_done) nxt = ce_n ? ST_RDY : ST_ACC;
        ST_RDY:  if (!ce_n) nxt = ST_ACC;
        ST_ACC:  if (ce_n || row_chg) nxt = ST_PRE;
                 else if (aa_done) nxt = ST_OPEN;
        ST_OPEN: if (ce_n || row_chg) nxt = ST_PRE;
        default: nxt = ST_PRE;
      endcase
    end
  end

  assign pre_start  = (nxt == ST_PRE) && ((state != ST_PRE) || low_supply);
  assign acc_start  = (nxt == ST_ACC) && (state != ST_ACC);
  assign open_start = (nxt == ST_OPEN) && (state == ST_ACC);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_PRE;
    else        state <= nxt;
  end

  seq_sat_counter #(.W(CNT_W), .RST_FULL(1'b0)) u_pre_cnt (
    .clk(clk), .rst_n(rst_n), .clr(pre_start), .cnt(pre_cnt));

  seq_sat_counter #(.W(CNT_W), .RST_FULL(1'b1)) u_acc_cnt (
    .clk(clk), .rst_n(rst_n), .clr(acc_start), .cnt(acc_cnt));

  // Open-row address: full latch at access start, column follows in page mode.
  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= '0;
    else if (acc_start) cur_q <= addr;
    else if ((state == ST_ACC || state == ST_OPEN) && !ce_n && !row_chg && !low_supply)
      cur_q[COL_W-1:0] <= addr[COL_W-1:0];
  end

  // Write hold register: loaded while the strobe is low, drained on release.
  assign pend_load = st_open && !low_supply && !ce_n && !we_n && !row_chg;
  assign wr_commit = pend_q && !low_supply && (we_n || ce_n || (addr != pend_addr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      pend_be_q   <= '0;
    end else if (low_supply) begin
      pend_q <= 1'b0;
    end else if (pend_load) begin
      pend_q      <= 1'b1;
      pend_addr_q <= addr;
      pend_data_q <= din;
      pend_be_q   <= lane_mask(ub_n, lb_n);
    end else if (wr_commit) begin
      pend_q <= 1'b0;
    end
  end

  seq_lane_array #(.DW(DATA_W), .LANES(LANES), .SW(STORE_W)) u_array (
    .clk    (clk),
    .wr_lane({LANES{wr_commit}} & pend_be_q),
    .waddr  (pend_addr_q[STORE_W-1:0]),
    .wdata  (pend_data_q),
    .raddr  (cur_q[STORE_W-1:0]),
    .rdata  (rdata)
  );

  assign rd_ok   = st_open && !low_supply && !ce_n && !oe_n && we_n;
  assign dout_en = rd_ok ? lane_mask(ub_n, lb_n) : 2'b00;
  assign dout    = rdata;
  assign busy    = (state == ST_PRE) || (state == ST_ACC);

endmodule

// File: rtl/sram_row_seq_chk.sv
module sram_row_seq_chk #(
  parameter int PRE_CYC = 3,
  parameter int AA_CYC  = 4,
  parameter int RC_CYC  = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       low_supply,
  input logic       ce_n,
  input logic       busy,
  input logic [1:0] dout_en,
  input logic       row_chg,
  input logic       st_open,
  input logic       pre_start,
  input logic       acc_start,
  input logic       open_start,
  input logic       wr_commit
);
  logic [15:0] since_pre, since_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= '0;
      since_acc <= '1;
    end else begin
      if (pre_start) since_pre <= '0;
      else if (since_pre != '1) since_pre <= since_pre + 1'b1;
      if (acc_start) since_acc <= '0;
      else if (since_acc != '1) since_acc <= since_acc + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (busy && dout_en == 2'b00)); // R1
  AST_PRE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> (32'(since_pre) >= PRE_CYC - 1)); // R2
  AST_ACCESS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    open_start |-> (32'(since_acc) == AA_CYC - 1)); // R3
  AST_ROW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_open && !ce_n && row_chg && !low_supply) |=> busy); // R4
  AST_CYCLE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> (32'(since_acc) >= RC_CYC - 1)); // R5
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_open && !ce_n && !row_chg && !low_supply) |=> !busy); // R6
  AST_OUT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dout_en) |-> (!ce_n && !busy)); // R7
  AST_LOW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply |-> !wr_commit); // R10
  AST_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply |=> busy); // R10

endmodule

bind sram_row_seq sram_row_seq_chk #(
  .PRE_CYC(PRE_CYC), .AA_CYC(AA_CYC), .RC_CYC(RC_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .low_supply(low_supply), .ce_n(ce_n), .busy(busy),
  .dout_en(dout_en), .row_chg(row_chg), .st_open(st_open), .pre_start(pre_start),
  .acc_start(acc_start), .open_start(open_start), .wr_commit(wr_commit)
);

// File: tb/sim_sram_row_seq.sv
module sim_sram_row_seq;
  localparam int PRE = 3;
  localparam int AA  = 4;
  localparam int RC  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic low_supply = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b0, lb_n = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dout_en;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sram_row_seq #(.PRE_CYC(PRE), .AA_CYC(AA), .RC_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .low_supply(low_supply), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .busy(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200; i++) begin
      if (!busy) break;
      step();
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      if (busy) n++;
      else break;
    end
  endtask

  task automatic open_at(input logic [16:0] a);
    ce_n = 1'b0; addr = a; step(); wait_ready();
  endtask

  task automatic wr_word(input logic [16:0] a, input logic [15:0] d,
                         input logic u_n, input logic l_n, input string req);
    addr = a; din = d; ub_n = u_n; lb_n = l_n; we_n = 1'b0; step();
    chk({req, " busy during page write"}, 32'(busy), 32'd0);
    we_n = 1'b1; step();
    ub_n = 1'b0; lb_n = 1'b0;
  endtask

  task automatic rd_word(input logic [16:0] a, output logic [15:0] d);
    addr = a; oe_n = 1'b0; we_n = 1'b1; step(); d = dout;
  endtask

  // R1: reset state, then ready after precharge.
  task automatic t_reset();
    step();
    chk("R1 busy in reset", 32'(busy), 32'd1);
    chk("R1 dout_en in reset", 32'(dout_en), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < PRE + 2; i++) step();
    chk("R1 ready after reset precharge", 32'(busy), 32'd0);
  endtask

  // R3: access latency from the ready state.
  task automatic t_latency();
    int n; logic [15:0] d;
    ce_n = 1'b0; addr = 17'h00100; oe_n = 1'b0;
    count_busy(n);
    chk("R3 access busy span", 32'(n), 32'(AA));
    wr_word(17'h00100, 16'hC0DE, 1'b0, 1'b0, "R8");
    rd_word(17'h00100, d);
    chk("R3 data after access", 32'(d), 32'hC0DE);
  endtask

  // R6, R8: page writes and reads inside one row.
  task automatic t_page();
    logic [15:0] d;
    for (int c = 0; c < 4; c++) wr_word(17'h00100 | 17'(c), 16'h1000 + 16'(c), 1'b0, 1'b0, "R6");
    for (int c = 3; c >= 0; c--) begin
      rd_word(17'h00100 | 17'(c), d);
      chk("R6 page read data", 32'(d), 32'(16'h1000 + 16'(c)));
      chk("R6 page busy", 32'(busy), 32'd0);
    end
  endtask

  // R7, R8: lane selects for writes and output drive.
  task automatic t_lanes();
    logic [15:0] d;
    wr_word(17'h00101, 16'hA5C3, 1'b0, 1'b0, "R8");
    wr_word(17'h00101, 16'h1234, 1'b1, 1'b0, "R8");
    rd_word(17'h00101, d);
    chk("R8 lower lane only", 32'(d), 32'hA534);
    wr_word(17'h00101, 16'h5678, 1'b0, 1'b1, "R8");
    rd_word(17'h00101, d);
    chk("R8 upper lane only", 32'(d), 32'h5634);
    ub_n = 1'b1; lb_n = 1'b0; step();
    chk("R7 lower lane enable", 32'(dout_en), 32'h1);
    ub_n = 1'b0; lb_n = 1'b1; step();
    chk("R7 upper lane enable", 32'(dout_en), 32'h2);
    ub_n = 1'b0; lb_n = 1'b0; step();
    chk("R7 both lanes", 32'(dout_en), 32'h3);
    oe_n = 1'b1; step();
    chk("R7 read strobe high", 32'(dout_en), 32'h0);
    oe_n = 1'b0; ub_n = 1'b1; lb_n = 1'b1; we_n = 1'b0; step();
    chk("R7 write strobe low", 32'(dout_en), 32'h0);
    we_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0; step();
  endtask

  // R2, R9: chip select high closes row and drains a pending write.
  task automatic t_ce_close();
    int n; logic [15:0] d;
    for (int i = 0; i < RC; i++) step();
    addr = 17'h00102; din = 16'hBEEF; we_n = 1'b0; step();
    ce_n = 1'b1; count_busy(n);
    chk("R2 precharge span", 32'(n), 32'(PRE));
    chk("R7 no drive with ce high", 32'(dout_en), 32'h0);
    we_n = 1'b1;
    open_at(17'h00102);
    rd_word(17'h00102, d);
    chk("R9 write drained by ce", 32'(d), 32'hBEEF);
  endtask

  // R4: row change after a long-open row.
  task automatic t_row_long();
    int n; logic [15:0] d;
    for (int i = 0; i < RC; i++) step();
    addr = 17'h00200; count_busy(n);
    chk("R4 row change busy span", 32'(n), 32'(PRE + AA));
    wr_word(17'h00200, 16'h7777, 1'b0, 1'b0, "R4");
    for (int i = 0; i < RC; i++) step();
    addr = 17'h00100; count_busy(n);
    chk("R4 return busy span", 32'(n), 32'(PRE + AA));
    rd_word(17'h00101, d);
    chk("R4 row data kept", 32'(d), 32'h5634);
  endtask

  // R5: row change right after opening waits for the cycle spacing.
  task automatic t_row_fast();
    int n; int exp_n;
    ce_n = 1'b1; step(); wait_ready();
    ce_n = 1'b0; addr = 17'h00300; count_busy(n);
    chk("R5 first access span", 32'(n), 32'(AA));
    addr = 17'h00304; count_busy(n);
    exp_n = ((PRE > RC - AA - 1) ? PRE : RC - AA - 1) + AA;
    chk("R5 random cycle spacing", 32'(n), 32'(exp_n));
  endtask

  // R10: low supply blocks writes and outputs.
  task automatic t_low_supply();
    logic [15:0] d;
    wr_word(17'h00306, 16'h0F0F, 1'b0, 1'b0, "R10");
    addr = 17'h00306; din = 16'hFFFF; we_n = 1'b0; step();
    low_supply = 1'b1; we_n = 1'b1; oe_n = 1'b0; step();
    chk("R10 busy in low supply", 32'(busy), 32'd1);
    chk("R10 outputs off", 32'(dout_en), 32'h0);
    step();
    low_supply = 1'b0; step(); wait_ready();
    rd_word(17'h00306, d);
    chk("R10 pending write dropped", 32'(d), 32'h0F0F);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_page();
    t_lanes();
    t_ce_close();
    t_row_long();
    t_row_fast();
    t_low_supply();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule